// File: doc/BRIEF.md
# Four-Bit Opcode-Selected ALU

This block is a purely combinational arithmetic/logic unit for two 4-bit operands. A 4-bit operation code selects one of sixteen functions: addition and subtraction, each with or without a carry or borrow input, shifts and rotates by an operand amount, bitwise logic, and a clear. Every arithmetic function runs through a single ripple-carry adder built from 1-bit full-adder cells. For subtraction, the adder receives the inverted second operand.

Besides the 4-bit result, the block drives a carry-out flag, a zero flag and a 16-bit display word. In one opcode the display word shows a fixed pair of ASCII characters. In all other opcodes it mirrors the result and the two flags, so a row of indicators can be wired straight to it.

Top module: `alu4_core`

## Requirements
- R1: Opcode 0000 gives result = (a + b) mod 16, and carry_out is bit 4 of the 5-bit sum.
- R2: Opcode 0001 gives result = (a + b + carry_in) mod 16, and carry_out is bit 4 of that sum.
- R3: Opcode 0010 computes a + (~b) + 1. The result is the low 4 bits, and carry_out is bit 4, which is 1 exactly when a >= b.
- R4: Opcode 0011 computes a + (~b) + (~carry_in). The result is the low 4 bits, and carry_out is the raw bit 4.
- R5: Opcode 0100 shifts a right by b positions and opcode 1110 shifts a left by b positions, filling with zeros. Any amount b >= 4 gives 0000.
- R6: Opcode 0101 shifts a right by b positions, filling with a[3]. Any amount b >= 4 gives four copies of a[3].
- R7: Opcode 0110 rotates a right and opcode 1111 rotates a left, each by (b mod 4) positions.
- R8: Opcodes 1000, 1001, 1010, 1011 and 1101 give a|b, a&b, a^b, ~a and ~(a&b) respectively. Opcode 0111 gives 0000.
- R9: carry_out is 0 for every opcode other than 0000 to 0011.
- R10: zero_flag is 1 exactly when result is 0000.
- R11: Under opcode 1100, display is 16'h4B56 (ASCII "KV"), result is 0000, zero_flag is 1 and carry_out is 0.
- R12: Under every opcode other than 1100, display[3:0] equals result, display[14] equals carry_out, display[15] equals zero_flag, and display[13:4] is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand, also the shift or rotate amount |
| carry_in | input | 1 | Carry or borrow input for opcodes 0001 and 0011 |
| opcode | input | 4 | Operation select |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Carry out of bit 3 for arithmetic opcodes, otherwise 0 |
| zero_flag | output | 1 | High when result is all zeros |
| display | output | 16 | Indicator word: the character pair, or the result and flags |

## Verification
The block holds no state, so any fault in the decode, the adder chain or the shifter shows at the ports in the same evaluation as the inputs that expose it. Because the input space has only 8192 points, every opcode is swept over every operand and carry combination. A broken carry link therefore shows as a wrong result or carry_out on the first operand pair that ripples through that link. A shifter that mishandles amounts of 4 or more shows as nonzero fill for b >= 4. The display word is checked on every vector, so a miswired flag bit shows wherever that flag is high.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_ADDC = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SUBB = 4'b0011,
    OP_SRL  = 4'b0100,
    OP_SRA  = 4'b0101,
    OP_ROR  = 4'b0110,
    OP_CLR  = 4'b0111,
    OP_OR   = 4'b1000,
    OP_AND  = 4'b1001,
    OP_XOR  = 4'b1010,
    OP_INV  = 4'b1011,
    OP_SHOW = 4'b1100,
    OP_NAND = 4'b1101,
    OP_SLL  = 4'b1110,
    OP_ROL  = 4'b1111
  } alu_op_e;

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBB);
  endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);

  logic half;

  always_comb begin
    half = x ^ y;
    s    = half ^ cin;
    cout = (x & y) | (half & cin);
  end

endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    fa_cell u_fa (
      .x    (x[i]),
      .y    (y[i]),
      .cin  (chain[i]),
      .s    (sum[i]),
      .cout (chain[i+1])
    );
  end

  assign cout = chain[WIDTH];

  // The cell chain must agree with a plain wide addition (R1, R3)
  always_comb begin
    p_chain_sum_r1: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin}))
      else $error("ripple chain disagrees with wide sum");
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] val,
  input  logic [WIDTH-1:0] amt,
  output logic [WIDTH-1:0] srl_out,
  output logic [WIDTH-1:0] sra_out,
  output logic [WIDTH-1:0] sll_out,
  output logic [WIDTH-1:0] ror_out,
  output logic [WIDTH-1:0] rol_out
);

  localparam int SHW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic           big;
  logic [SHW-1:0] rot;

  always_comb begin
    big = (int'(amt) >= WIDTH);
    rot = amt[SHW-1:0];
  end

  always_comb begin
    if (big) begin
      srl_out = '0;
      sll_out = '0;
      sra_out = {WIDTH{val[WIDTH-1]}};
    end else begin
      srl_out = val >> amt;
      sll_out = val << amt;
      sra_out = WIDTH'($signed(val) >>> amt);
    end
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      ror_out[i] = val[(i + int'(rot)) % WIDTH];
      rol_out[i] = val[(i + WIDTH - int'(rot)) % WIDTH];
    end
  end

  always_comb begin
    // R7: a rotate moves bits, it neither creates nor drops any
    p_rot_keeps_ones_r7: assert ($countones(ror_out) == $countones(val) &&
                                 $countones(rol_out) == $countones(val))
      else $error("rotate changed the ones count");
    // R5: a zero-filled right shift never makes the value larger
    p_srl_not_larger_r5: assert (srl_out <= val)
      else $error("logical right shift grew the value");
    // R6: the sign bit is kept by the arithmetic right shift
    p_sra_sign_r6: assert (sra_out[WIDTH-1] == val[WIDTH-1])
      else $error("arithmetic shift lost the sign bit");
  end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int          WIDTH  = 4,
  parameter int          DISP_W = 16,
  parameter logic [15:0] GLYPH  = 16'h4B56
) (
  input  logic [3:0]  op_a,
  input  logic [3:0]  op_b,
  input  logic        carry_in,
  input  logic [3:0]  opcode,
  output logic [3:0]  result,
  output logic        carry_out,
  output logic        zero_flag,
  output logic [15:0] display
);

  localparam int PAD = DISP_W - 2 - WIDTH;

  alu_op_e    op;
  logic [WIDTH-1:0] add_y;
  logic             add_ci;
  logic [WIDTH-1:0] add_sum;
  logic             add_co;
  logic [WIDTH-1:0] srl_v, sra_v, sll_v, ror_v, rol_v;

  assign op = alu_op_e'(opcode);

  // Operand steering into the shared adder
  always_comb begin
    unique case (op)
      OP_ADDC: begin add_y = op_b;  add_ci = carry_in;  end
      OP_SUB:  begin add_y = ~op_b; add_ci = 1'b1;      end
      OP_SUBB: begin add_y = ~op_b; add_ci = ~carry_in; end
      default: begin add_y = op_b;  add_ci = 1'b0;      end
    endcase
  end

  ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x    (op_a),
    .y    (add_y),
    .cin  (add_ci),
    .sum  (add_sum),
    .cout (add_co)
  );

  shift_unit #(.WIDTH(WIDTH)) u_shift (
    .val     (op_a),
    .amt     (op_b),
    .srl_out (srl_v),
    .sra_out (sra_v),
    .sll_out (sll_v),
    .ror_out (ror_v),
    .rol_out (rol_v)
  );

  // Result selection
  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: result = add_sum;
      OP_SRL:  result = srl_v;
      OP_SRA:  result = sra_v;
      OP_ROR:  result = ror_v;
      OP_OR:   result = op_a | op_b;
      OP_AND:  result = op_a & op_b;
      OP_XOR:  result = op_a ^ op_b;
      OP_INV:  result = ~op_a;
      OP_NAND: result = ~(op_a & op_b);
      OP_SLL:  result = sll_v;
      OP_ROL:  result = rol_v;
      default: result = '0;
    endcase
  end

  // Flags and indicator word
  always_comb begin
    carry_out = is_arith(op) & add_co;
    zero_flag = ~|result;
    if (op == OP_SHOW) display = GLYPH;
    else               display = {zero_flag, carry_out, {PAD{1'b0}}, result};
  end

  always_comb begin
    // R9: no carry leaks out of a non-arithmetic opcode
    p_logic_nocarry_r9: assert (is_arith(op) || !carry_out)
      else $error("carry_out set by non-arithmetic opcode");
    // R8: the clear opcode yields zero and raises the zero flag
    p_clr_zero_r8: assert (op != OP_CLR || (result == '0 && zero_flag))
      else $error("clear opcode produced nonzero result");
    // R11: character mode shows the fixed glyph pair with a zero result
    p_show_glyph_r11: assert (op != OP_SHOW || (display == GLYPH && result == '0 && zero_flag))
      else $error("character mode display wrong");
    // R12: elsewhere the indicator word mirrors result and flags
    p_disp_mirror_r12: assert (op == OP_SHOW ||
                               (display[WIDTH-1:0] == result && display[DISP_W-1] == zero_flag &&
                                display[DISP_W-2] == carry_out))
      else $error("display does not mirror result and flags");
  end

endmodule

// File: tb/alu4_core_test.sv
module alu4_core_test;

  logic        clk;
  logic [3:0]  op_a, op_b, opcode;
  logic        carry_in;
  logic [3:0]  result;
  logic        carry_out, zero_flag;
  logic [15:0] display;

  int checks   = 0;
  int failures = 0;

  alu4_core uut (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .opcode    (opcode),
    .result    (result),
    .carry_out (carry_out),
    .zero_flag (zero_flag),
    .display   (display)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h (op=%b a=%0h b=%0h ci=%0b)",
               tag, what, act, exp, opcode, op_a, op_b, carry_in);
    end
  endtask

  // Independent reference model taken from the requirement list
  task automatic model(input int op, input int a, input int b, input int ci,
                       output int r, output int co);
    int s, k;
    co = 0;
    k  = b % 4;
    case (op)
      0:  begin s = a + b;             r = s & 15; co = s >> 4; end
      1:  begin s = a + b + ci;        r = s & 15; co = s >> 4; end
      2:  begin s = a + (15 - b) + 1;  r = s & 15; co = s >> 4; end
      3:  begin s = a + (15 - b) + (1 - ci); r = s & 15; co = s >> 4; end
      4:  r = (b >= 4) ? 0 : (a >> b);
      5:  begin
            if (b >= 4) r = (a & 8) ? 15 : 0;
            else begin
              r = a >> b;
              if ((a & 8) != 0) r = r | ((15 << (4 - b)) & 15);
            end
          end
      6:  r = ((a >> k) | (a << (4 - k))) & 15;
      7:  r = 0;
      8:  r = a | b;
      9:  r = a & b;
      10: r = a ^ b;
      11: r = (~a) & 15;
      12: r = 0;
      13: r = (~(a & b)) & 15;
      14: r = (b >= 4) ? 0 : ((a << b) & 15);
      default: r = ((a << k) | (a >> (4 - k))) & 15;
    endcase
  endtask

  task automatic sweep(input int op, input string tag);
    int r, co, z, d;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int ci = 0; ci < 2; ci++) begin
          @(negedge clk);
          opcode = 4'(op); op_a = 4'(a); op_b = 4'(b); carry_in = ci[0];
          #1;
          model(op, a, b, ci, r, co);
          z = (r == 0) ? 1 : 0;
          d = (op == 12) ? 32'h4B56 : ((z << 15) | (co << 14) | r);
          check(tag, "result", int'(result), r);
          check((op < 4) ? tag : "R9", "carry_out", int'(carry_out), co);
          check("R10", "zero_flag", int'(zero_flag), z);
          check((op == 12) ? "R11" : "R12", "display", int'(display), d);
        end
      end
    end
  endtask

  task automatic test_idle();
    @(negedge clk);
    opcode = 4'd0; op_a = 4'd0; op_b = 4'd0; carry_in = 1'b0;
    #1;
    check("R1", "idle result", int'(result), 0);
    check("R10", "idle zero_flag", int'(zero_flag), 1);
    check("R12", "idle display", int'(display), 32'h8000);
  endtask

  task automatic test_add();
    sweep(0, "R1");
    sweep(1, "R2");
  endtask

  task automatic test_sub();
    sweep(2, "R3");
    sweep(3, "R4");
    // Corner: 0 - 1 - borrow wraps to 1110 with no carry out (R4)
    @(negedge clk);
    opcode = 4'b0011; op_a = 4'd0; op_b = 4'd1; carry_in = 1'b1;
    #1;
    check("R4", "wrap result", int'(result), 14);
    check("R4", "wrap carry", int'(carry_out), 0);
  endtask

  task automatic test_shift();
    sweep(4, "R5");
    sweep(14, "R5");
    sweep(5, "R6");
  endtask

  task automatic test_rotate();
    sweep(6, "R7");
    sweep(15, "R7");
  endtask

  task automatic test_logic();
    sweep(7, "R8");
    sweep(8, "R8");
    sweep(9, "R8");
    sweep(10, "R8");
    sweep(11, "R8");
    sweep(13, "R8");
  endtask

  task automatic test_show();
    sweep(12, "R11");
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    opcode = 4'd0; op_a = 4'd0; op_b = 4'd0; carry_in = 1'b0;
    test_idle();
    test_add();
    test_sub();
    test_shift();
    test_rotate();
    test_logic();
    test_show();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule